// File: doc/BRIEF.md
# Serial Flash Write-Enable Latch Controller

This block is the command-side front end of a serial NOR flash device. It takes in a one-byte command code while chip select is held low, with one, two or four bits arriving per serial clock edge according to a bus-width mode input. It keeps the write enable latch, which is the single bit that permits any state-changing command. It also keeps a sticky protection-error flag.

A command acts only if chip select goes high exactly after the eighth command bit. If the frame is cut short, or runs past the byte, it is dropped without trace.

Write enable sets the latch and write disable clears it. State-changing commands (program, erase, status write, enter and leave wide addressing) are accepted only while the latch is set. An accepted command either completes, which pulses an output and drops the latch, or hits a protected region, which raises the error flag and leaves the latch set. While the error flag is set, write disable has no effect. Only the clear-flags command removes both the flag and the latch.

Top module: `cmd_wel_ctrl`

## Requirements
- R1: After reset (rstN low) the latch (statusOut[0]) and the protection error flag (statusOut[1]) are 0, and modifyPulse is 0.
- R2: A command takes effect only at the first clock edge with csN high when exactly 8 command bits were shifted while csN was low. A frame with fewer or more bits leaves statusOut unchanged and gives no pulse.
- R3: busMode 0 shifts DQ[0] per edge, 1 shifts DQ[1:0], 2 shifts DQ[3:0], and 3 behaves like 0. Bits arrive MSB first, with the higher DQ line carrying the more significant bit.
- R4: Opcode 06h sets the latch.
- R5: Opcode 04h clears the latch when the error flag is 0. It has no effect when the error flag is 1.
- R6: The gated opcodes 02h, 20h, D8h, 01h, B7h and E9h are ignored when the latch is 0: no pulse and no flag change.
- R7: A gated opcode committed while the latch is 1 and protHit is 0 makes modifyPulse high for exactly the one cycle after the commit edge, and clears the latch.
- R8: A gated opcode committed while the latch is 1 and protHit is 1 sets the error flag, keeps the latch at 1, and gives no pulse.
- R9: Opcode 50h clears both the latch and the error flag.
- R10: Clock edges while csN is high shift no bits, so DQ activity then cannot form or corrupt a command.
- R11: Any other complete opcode leaves statusOut unchanged and gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; bits are sampled on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select framing one command |
| dq | input | 4 | Serial data lines |
| busMode | input | 2 | Bits per edge: 0 one, 1 two, 2 four, 3 one |
| protHit | input | 1 | High when the committed command targets a protected region |
| statusOut | output | 2 | {protection error flag, write enable latch} |
| modifyPulse | output | 1 | One-cycle report of a completed gated command |

## Verification
A miscounted bit counter or a mis-ordered shift shows up at the commit edge. The latch then changes on a frame that should be dropped, or fails to change on a good one, and statusOut shows this one cycle after chip select rises. A wrong error-flag state shows only at the next write disable or gated command, as a latch that clears when it should hold, or a pulse where none is due. The vectors therefore put write disable and gated commands directly after each flag transition, so that such a fault shows up within one command frame.

// File: rtl/wel_pkg.sv
package wel_pkg;
  localparam int CMD_BITS = 8;
  localparam int DQ_W = 4;

  localparam logic [1:0] MODE_EXT  = 2'd0;
  localparam logic [1:0] MODE_DUAL = 2'd1;
  localparam logic [1:0] MODE_QUAD = 2'd2;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_CLRF  = 8'h50;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_SSE   = 8'h20;
  localparam logic [7:0] OP_SE    = 8'hD8;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_EN4B  = 8'hB7;
  localparam logic [7:0] OP_EX4B  = 8'hE9;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic setErr;
    logic clrErr;
    logic pulse;
  } welStrobe_t;
endpackage

// File: rtl/wel_datapath.sv
module wel_datapath
  import wel_pkg::*;
#(
  parameter int BITS = CMD_BITS,
  parameter int LANES = DQ_W,
  localparam int CNT_W = $clog2(BITS + LANES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic [LANES-1:0] dq,
  input  logic [1:0]       busMode,
  input  welStrobe_t       strobes,
  output logic [BITS-1:0]  cmdByte,
  output logic [CNT_W-1:0] bitCnt,
  output logic             wel,
  output logic             protErr,
  output logic             modifyPulse
);
  logic [BITS-1:0]  shiftNext;
  logic [CNT_W-1:0] stepSize;

  always_comb begin
    case (busMode)
      MODE_DUAL: begin
        shiftNext = {cmdByte[BITS-3:0], dq[1:0]};
        stepSize  = CNT_W'(2);
      end
      MODE_QUAD: begin
        shiftNext = {cmdByte[BITS-5:0], dq[3:0]};
        stepSize  = CNT_W'(4);
      end
      default: begin
        shiftNext = {cmdByte[BITS-2:0], dq[0]};
        stepSize  = CNT_W'(1);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdByte <= '0;
      bitCnt  <= '0;
    end else if (csN) begin
      cmdByte <= '0;
      bitCnt  <= '0;
    end else if (bitCnt <= CNT_W'(BITS)) begin
      cmdByte <= shiftNext;
      bitCnt  <= bitCnt + stepSize;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wel         <= 1'b0;
      protErr     <= 1'b0;
      modifyPulse <= 1'b0;
    end else begin
      modifyPulse <= strobes.pulse;
      if (strobes.clrErr)      protErr <= 1'b0;
      else if (strobes.setErr) protErr <= 1'b1;
      if (strobes.setWel)      wel <= 1'b1;
      else if (strobes.clrWel) wel <= 1'b0;
    end
  end
endmodule

// File: rtl/wel_control.sv
module wel_control
  import wel_pkg::*;
#(
  parameter int BITS = CMD_BITS,
  parameter int CNT_W = 4
) (
  input  logic             csN,
  input  logic [BITS-1:0]  cmdByte,
  input  logic [CNT_W-1:0] bitCnt,
  input  logic             wel,
  input  logic             protErr,
  input  logic             protHit,
  output welStrobe_t       strobes
);
  logic commit;
  logic gatedOp;

  assign commit = csN && (bitCnt == CNT_W'(BITS));

  always_comb begin
    case (cmdByte)
      OP_PROG, OP_SSE, OP_SE, OP_WRSR, OP_EN4B, OP_EX4B: gatedOp = 1'b1;
      default: gatedOp = 1'b0;
    endcase
  end

  always_comb begin
    strobes = '0;
    if (commit) begin
      case (cmdByte)
        OP_WREN: strobes.setWel = 1'b1;
        OP_WRDI: strobes.clrWel = !protErr;
        OP_CLRF: begin
          strobes.clrWel = 1'b1;
          strobes.clrErr = 1'b1;
        end
        default: begin
          if (gatedOp && wel) begin
            if (protHit) begin
              strobes.setErr = 1'b1;
            end else begin
              strobes.clrWel = 1'b1;
              strobes.pulse  = 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/cmd_wel_ctrl.sv
module cmd_wel_ctrl
  import wel_pkg::*;
#(
  parameter int BITS = CMD_BITS,
  parameter int LANES = DQ_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic [LANES-1:0] dq,
  input  logic [1:0]       busMode,
  input  logic             protHit,
  output logic [1:0]       statusOut,
  output logic             modifyPulse
);
  localparam int CNT_W = $clog2(BITS + LANES + 1);

  welStrobe_t       strobes;
  logic [BITS-1:0]  cmdByte;
  logic [CNT_W-1:0] bitCnt;
  logic             wel;
  logic             protErr;

  wel_datapath #(.BITS(BITS), .LANES(LANES)) uDp (
    .clk(clk), .rstN(rstN), .csN(csN), .dq(dq), .busMode(busMode),
    .strobes(strobes), .cmdByte(cmdByte), .bitCnt(bitCnt),
    .wel(wel), .protErr(protErr), .modifyPulse(modifyPulse)
  );

  wel_control #(.BITS(BITS), .CNT_W(CNT_W)) uCtl (
    .csN(csN), .cmdByte(cmdByte), .bitCnt(bitCnt), .wel(wel),
    .protErr(protErr), .protHit(protHit), .strobes(strobes)
  );

  assign statusOut = {protErr, wel};
endmodule

// File: rtl/cmd_wel_checker.sv
module cmd_wel_checker (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic [1:0] statusOut,
  input logic       modifyPulse
);
  // R7: the completion report lasts one cycle
  a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    modifyPulse |=> !modifyPulse);
  // R7: completion drops the latch
  a_r7_pulse_drops_wel: assert property (@(posedge clk) disable iff (!rstN)
    modifyPulse |-> !statusOut[0]);
  // R6: completion needs the latch set beforehand
  a_r6_pulse_needs_wel: assert property (@(posedge clk) disable iff (!rstN)
    modifyPulse |-> $past(statusOut[0]));
  // R8: a protection error appears only with the latch held
  a_r8_err_keeps_wel: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusOut[1]) |-> statusOut[0]);
  // R9: the error flag only falls together with the latch cleared
  a_r9_err_clear_both: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusOut[1]) |-> !statusOut[0]);
  // R2: status changes only on an edge with chip select high
  a_r2_commit_on_cs_high: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && $past(!csN)) |-> ($stable(statusOut) && !modifyPulse));
endmodule

bind cmd_wel_ctrl cmd_wel_checker uChk (
  .clk(clk), .rstN(rstN), .csN(csN),
  .statusOut(statusOut), .modifyPulse(modifyPulse)
);

// File: tb/tb_cmd_wel_ctrl.sv
module tb_cmd_wel_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1;
  logic [3:0] dq = 4'h0;
  logic [1:0] busMode = 2'd0;
  logic       protHit = 1'b0;
  logic [1:0] statusOut;
  logic       modifyPulse;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cmd_wel_ctrl dut (
    .clk(clk), .rstN(rstN), .csN(csN), .dq(dq), .busMode(busMode),
    .protHit(protHit), .statusOut(statusOut), .modifyPulse(modifyPulse)
  );

  // {mode[1:0], op[7:0], extra, short, prot, expWel, expErr, expPulse}
  localparam int NV = 23;
  localparam logic [15:0] VEC [NV] = '{
    {2'd0, 8'h02, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 gated, wel 0
    {2'd0, 8'h06, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R4 R3 ext
    {2'd1, 8'h04, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 R3 dual
    {2'd2, 8'h06, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R4 R3 quad
    {2'd0, 8'h02, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R7 program
    {2'd2, 8'h06, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R4
    {2'd1, 8'hD8, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R8 protected
    {2'd0, 8'h04, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R5 held by err
    {2'd1, 8'h02, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R8 again
    {2'd2, 8'h50, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R9
    {2'd0, 8'h06, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 nine bits
    {2'd1, 8'h06, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 six bits
    {2'd3, 8'h06, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R3 mode 3
    {2'd2, 8'h04, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R2 twelve bits
    {2'd0, 8'hB7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R7 enter 4B
    {2'd1, 8'h06, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R4
    {2'd2, 8'hE9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R7 exit 4B
    {2'd0, 8'h06, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R4
    {2'd1, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R7 status write
    {2'd2, 8'h20, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 wel 0
    {2'd0, 8'h06, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R4
    {2'd0, 8'h9F, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R11 other
    {2'd2, 8'h20, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}  // R7 subsector
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sendCmd(input logic [1:0] m, input logic [7:0] op,
                         input int edges, input logic prot);
    int s;
    s = (m == 2'd1) ? 2 : (m == 2'd2) ? 4 : 1;
    for (int k = 0; k < edges; k++) begin
      @(negedge clk);
      csN = 1'b0;
      busMode = m;
      if (s * (k + 1) <= 8)
        dq = 4'((op >> (8 - s * (k + 1))) & ((1 << s) - 1));
      else
        dq = 4'hF;
    end
    @(negedge clk);
    csN = 1'b1;
    dq = 4'h0;
    protHit = prot;
    @(negedge clk);
    protHit = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset status", {2'b0, statusOut}, 4'h0);
    check("R1 reset pulse", {3'b0, modifyPulse}, 4'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [15:0] v;
      int s;
      int edges;
      v = VEC[i];
      s = (v[15:14] == 2'd1) ? 2 : (v[15:14] == 2'd2) ? 4 : 1;
      edges = 8 / s + (v[5] ? 1 : 0) - (v[4] ? 1 : 0);
      sendCmd(v[15:14], v[13:6], edges, v[3]);
      check($sformatf("R2-R11 vector %0d latch", i), {3'b0, statusOut[0]}, {3'b0, v[2]});
      check($sformatf("R5 R8 R9 vector %0d errflag", i), {3'b0, statusOut[1]}, {3'b0, v[1]});
      check($sformatf("R6 R7 vector %0d pulse", i), {3'b0, modifyPulse}, {3'b0, v[0]});
    end

    // R7: pulse lasts one cycle only
    sendCmd(2'd0, 8'h06, 8, 1'b0);
    sendCmd(2'd0, 8'h02, 8, 1'b0);
    check("R7 pulse high", {3'b0, modifyPulse}, 4'h1);
    @(negedge clk);
    check("R7 pulse gone", {3'b0, modifyPulse}, 4'h0);

    // R10: activity with csN high forms no command
    dq = 4'hF;
    busMode = 2'd2;
    repeat (10) @(negedge clk);
    dq = 4'h0;
    check("R10 idle clocks", {2'b0, statusOut}, 4'h0);
    sendCmd(2'd0, 8'h06, 8, 1'b0);
    check("R10 clean command after idle", {2'b0, statusOut}, 4'h1);

    // R1: reset mid-operation clears flag and latch
    sendCmd(2'd1, 8'hD8, 4, 1'b1);
    check("R8 err before reset", {2'b0, statusOut}, 4'h3);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset clears", {2'b0, statusOut}, 4'h0);
    rstN = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule